// File: doc/BRIEF.md
# Serial Control Port With Register Bank

This block is a slave on a four-wire serial control link: an active-low select, a control clock, a serial data input and a serial data output with its own output enable. A controller sends one- or two-byte instructions, MSB first, to write or read a bank of sixteen 8-bit configuration registers and to set a power-down flag. The first byte of every instruction is a header; its decode decides whether a second byte follows. A write loads the second byte into the addressed register. A read returns the addressed register on the data output while the controller clocks a second byte. A header with its two-byte flag cleared is a complete instruction on its own and changes only the power state.

The two bytes of an instruction may share one select window of sixteen clocks or arrive in two windows of eight clocks each. The register bank and the decoder run on the control clock, which may be unrelated to the system clock. Every completed instruction flips an event toggle. A synchronizer carries that toggle into the system clock domain, where a shadow copy of the bank and the power flag is refreshed for the rest of the chip.

Top module: `ctlport_top`

## Requirements
- R1: A byte is taken from `cdi` on eight rising edges of `cclk` while `sel_n` is low, most significant bit first.
- R2: Header byte layout: bit 7 is the power bit (0 = power up, 1 = power down), bits 6:3 the register address, bit 2 selects read (1) or write (0), bit 1 set means a second byte follows, bit 0 is ignored.
- R3: A write header followed by a data byte loads the data into the addressed register at the eighth rising edge of the data byte, whether the data byte follows in the same select window or in a new one.
- R4: A read header followed by a second byte makes `cdo` present the addressed register MSB first, each bit changing on a falling edge of `cclk` so that it is valid at the rising edge of the matching bit of the second byte; a read leaves every register unchanged.
- R5: `cdo_oe` is low whenever `sel_n` is high and high whenever `sel_n` is low.
- R6: A header with bit 1 cleared sets the power state from bit 7 and leaves every register unchanged; its address and read bits have no effect.
- R7: A two-byte instruction applies its header's power bit when its second byte completes.
- R8: If `sel_n` rises before eight clocks of a byte have been taken, the partial byte is discarded and the decoder returns to idle, forgetting any pending second byte; the next byte is decoded as a header.
- R9: Writes are accepted in either power state.
- R10: After reset every register reads 0 and `pwr_down` is 1.
- R11: `cfg_regs` and `pwr_down` follow the bank and power state a few system clocks after each completed instruction and hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| sel_n | input | 1 | Active-low select from the controller |
| cclk | input | 1 | Serial control clock, idles low |
| cdi | input | 1 | Serial data in, sampled on rising `cclk` |
| cdo | output | 1 | Serial read data, updated on falling `cclk` |
| cdo_oe | output | 1 | Output enable for `cdo` (high impedance when low) |
| cfg_regs | output | 128 | Register bank in the system domain, register n at bits 8n+7:8n |
| pwr_down | output | 1 | Power-down flag in the system domain |

## Verification
The bench targets the split-window forms, where a decoder that cleared its state on select high would drop the second byte and never update the register or would return garbage on reads. It aborts windows both in a header and in a pending data byte, then sends a single-byte power command: a decoder that kept the pending write would store that command byte in the register and take the wrong power bit. Read data is compared bit by bit at rising edges, so an output that changed one edge late or shifted on the rising edge shows as a wrong byte, and single-byte commands carry junk in their address and read bits to expose decoders that look at them.

// File: rtl/ctlport_pkg.sv
package ctlport_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int NREG   = 1 << ADDR_W;

  typedef enum logic [1:0] {ST_IDLE, ST_WR2, ST_RD2} dec_state_t;

  typedef struct packed {
    logic              pwr;
    logic [ADDR_W-1:0] addr;
    logic              rd;
    logic              two;
    logic              rsv;
  } hdr_t;

  function automatic hdr_t decode_hdr(input logic [DATA_W-1:0] b);
    return hdr_t'(b);
  endfunction

  function automatic dec_state_t next_after_hdr(input hdr_t h);
    if (!h.two)     return ST_IDLE;
    else if (h.rd)  return ST_RD2;
    else            return ST_WR2;
  endfunction

  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] s,
                                                 input logic bit_in);
    return {s[DATA_W-2:0], bit_in};
  endfunction
endpackage

// File: rtl/ctlport_rx.sv
module ctlport_rx
  import ctlport_pkg::*;
(
  input  logic              cclk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              cdi,
  output logic              byte_done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              abort_evt
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sreg;
  logic              ab_tog, ab_ack;

  // bit counter, cleared whenever select is released
  always_ff @(posedge cclk or negedge rst_n or posedge sel_n) begin
    if (!rst_n)      cnt <= '0;
    else if (sel_n)  cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  always_ff @(posedge cclk or negedge rst_n) begin
    if (!rst_n)      sreg <= '0;
    else if (!sel_n) sreg <= shift_in(sreg, cdi);
  end

  // a window closing mid-byte flips this toggle
  always_ff @(posedge sel_n or negedge rst_n) begin
    if (!rst_n)            ab_tog <= 1'b0;
    else if (cnt != '0)    ab_tog <= ~ab_tog;
  end

  always_ff @(posedge cclk or negedge rst_n) begin
    if (!rst_n) ab_ack <= 1'b0;
    else        ab_ack <= ab_tog;
  end

  assign byte_done = (cnt == CNT_W'(DATA_W-1)) && !sel_n;
  assign rx_byte   = shift_in(sreg, cdi);
  assign abort_evt = ab_ack ^ ab_tog;

  p_cnt_restart_r1: assert property (@(posedge cclk) disable iff (!rst_n)
    byte_done |=> (cnt == '0) || !$stable(ab_tog) || (cnt == CNT_W'(1)))
    else $error("byte counter did not restart after a full byte");
endmodule

// File: rtl/ctlport_dec.sv
module ctlport_dec
  import ctlport_pkg::*;
(
  input  logic                   cclk,
  input  logic                   rst_n,
  input  logic                   byte_done,
  input  logic [DATA_W-1:0]      rx_byte,
  input  logic                   abort_evt,
  output logic [NREG*DATA_W-1:0] bank_flat,
  output logic                   pwr_q,
  output logic                   evt_tog,
  output logic                   cdo_q
);
  dec_state_t        state;
  hdr_t              hdr_q, rx_hdr;
  logic [DATA_W-1:0] rd_sreg;
  logic [DATA_W-1:0] bank [NREG];
  logic              wr_stb, pwr_stb, hdr_stb;

  assign rx_hdr  = decode_hdr(rx_byte);
  assign hdr_stb = byte_done && !abort_evt && (state == ST_IDLE);
  assign wr_stb  = byte_done && !abort_evt && (state == ST_WR2);
  assign pwr_stb = byte_done && !abort_evt && ((state != ST_IDLE) || !rx_hdr.two);

  always_ff @(posedge cclk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      hdr_q   <= '0;
      pwr_q   <= 1'b1;
      evt_tog <= 1'b0;
      rd_sreg <= '0;
    end else if (abort_evt) begin
      state <= ST_IDLE;
    end else if (hdr_stb) begin
      hdr_q <= rx_hdr;
      state <= next_after_hdr(rx_hdr);
      if (rx_hdr.two && rx_hdr.rd) rd_sreg <= bank[rx_hdr.addr];
      if (!rx_hdr.two) begin
        pwr_q   <= rx_hdr.pwr;
        evt_tog <= ~evt_tog;
      end
    end else if (byte_done) begin
      pwr_q   <= hdr_q.pwr;
      evt_tog <= ~evt_tog;
      state   <= ST_IDLE;
    end else if (state == ST_RD2) begin
      rd_sreg <= shift_in(rd_sreg, 1'b0);
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge cclk or negedge rst_n) begin
      if (!rst_n)                                        bank[i] <= '0;
      else if (wr_stb && (hdr_q.addr == ADDR_W'(i)))     bank[i] <= rx_byte;
    end
    assign bank_flat[i*DATA_W +: DATA_W] = bank[i];
  end

  // read data leaves on the falling edge
  always_ff @(negedge cclk or negedge rst_n) begin
    if (!rst_n) cdo_q <= 1'b0;
    else        cdo_q <= rd_sreg[DATA_W-1];
  end

  p_bank_hold_r3: assert property (@(posedge cclk) disable iff (!rst_n)
    !wr_stb |=> $stable(bank_flat))
    else $error("register bank changed without a write");

  p_pwr_hold_r6: assert property (@(posedge cclk) disable iff (!rst_n)
    !pwr_stb |=> $stable(pwr_q))
    else $error("power state changed without an instruction");

  p_evt_flip_r11: assert property (@(posedge cclk) disable iff (!rst_n)
    pwr_stb |=> (evt_tog != $past(evt_tog)))
    else $error("completed instruction did not flip the event toggle");

  p_read_no_write_r4: assert property (@(posedge cclk) disable iff (!rst_n)
    (state == ST_RD2) |=> $stable(bank_flat))
    else $error("read disturbed the register bank");
endmodule

// File: rtl/ctlport_cdc.sv
module ctlport_cdc
  import ctlport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   evt_tog,
  input  logic [NREG*DATA_W-1:0] bank_flat,
  input  logic                   pwr_q,
  output logic [NREG*DATA_W-1:0] cfg_regs,
  output logic                   pwr_down
);
  logic [SYNC_STAGES:0] chain;
  logic                 upd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[SYNC_STAGES-1:0], evt_tog};
  end

  assign upd = chain[SYNC_STAGES] ^ chain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_regs <= '0;
      pwr_down <= 1'b1;
    end else if (upd) begin
      cfg_regs <= bank_flat;
      pwr_down <= pwr_q;
    end
  end

  p_shadow_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(cfg_regs) && $stable(pwr_down)))
    else $error("system copy moved without an event");
endmodule

// File: rtl/ctlport_top.sv
module ctlport_top
  import ctlport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sel_n,
  input  logic                   cclk,
  input  logic                   cdi,
  output logic                   cdo,
  output logic                   cdo_oe,
  output logic [NREG*DATA_W-1:0] cfg_regs,
  output logic                   pwr_down
);
  logic                   byte_done, abort_evt, pwr_q, evt_tog, cdo_q;
  logic [DATA_W-1:0]      rx_byte;
  logic [NREG*DATA_W-1:0] bank_flat;

  ctlport_rx u_rx (
    .cclk(cclk), .rst_n(rst_n), .sel_n(sel_n), .cdi(cdi),
    .byte_done(byte_done), .rx_byte(rx_byte), .abort_evt(abort_evt)
  );

  ctlport_dec u_dec (
    .cclk(cclk), .rst_n(rst_n), .byte_done(byte_done), .rx_byte(rx_byte),
    .abort_evt(abort_evt), .bank_flat(bank_flat), .pwr_q(pwr_q),
    .evt_tog(evt_tog), .cdo_q(cdo_q)
  );

  ctlport_cdc #(.SYNC_STAGES(SYNC_STAGES)) u_cdc (
    .clk(clk), .rst_n(rst_n), .evt_tog(evt_tog), .bank_flat(bank_flat),
    .pwr_q(pwr_q), .cfg_regs(cfg_regs), .pwr_down(pwr_down)
  );

  assign cdo    = cdo_q;
  assign cdo_oe = ~sel_n;
endmodule

// File: tb/tb_ctlport_top.sv
module tb_ctlport_top;
  logic         clk = 1'b0, rst_n = 1'b0, sel_n = 1'b1, cclk = 1'b0, cdi = 1'b0;
  logic         cdo, cdo_oe, pwr_down;
  logic [127:0] cfg_regs;

  ctlport_top dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .cclk(cclk), .cdi(cdi),
    .cdo(cdo), .cdo_oe(cdo_oe), .cfg_regs(cfg_regs), .pwr_down(pwr_down)
  );

  always #4 clk = ~clk;

  int          n_cmp = 0, n_bad = 0;
  logic [7:0]  model [16];
  logic        model_pwr;
  logic [7:0]  exp_q [$];
  logic [7:0]  mon_byte;
  event        mon_ev;
  bit          done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] model_flat();
    logic [127:0] f;
    for (int i = 0; i < 16; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  // monitor: compares each captured read byte with the oldest expectation
  initial begin
    forever begin
      @(mon_ev);
      if (exp_q.size() == 0) check(1'b0, "R4 unexpected read", {120'd0, mon_byte}, 128'd0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(mon_byte === e, "R4 read data", {120'd0, mon_byte}, {120'd0, e});
      end
    end
  end

  task automatic sel_low();
    sel_n = 1'b0; #10;
    check(cdo_oe === 1'b1, "R5 oe with select low", {127'd0, cdo_oe}, 128'd1);
  endtask

  task automatic sel_high();
    #10 sel_n = 1'b1; #10;
    check(cdo_oe === 1'b0, "R5 oe with select high", {127'd0, cdo_oe}, 128'd0);
  endtask

  task automatic shift_bits(input logic [7:0] b, input int n, input bit cap);
    logic [7:0] got = '0;
    for (int i = 7; i > 7 - n; i--) begin
      cdi = b[i]; #10;
      got = {got[6:0], cdo};
      cclk = 1'b1; #20;
      cclk = 1'b0; #10;
    end
    if (cap) begin
      mon_byte = got;
      -> mon_ev;
      #1;
    end
  endtask

  task automatic settle_and_check(input string req);
    #240;
    check(cfg_regs === model_flat(), req, cfg_regs, model_flat());
    check(pwr_down === model_pwr, req, {127'd0, pwr_down}, {127'd0, model_pwr});
  endtask

  // header: {pwr, addr[3:0], rd, two, rsv}
  task automatic do_write(input logic [3:0] a, input logic [7:0] d, input logic p,
                          input bit split, input logic rsv, input string req);
    sel_low();
    shift_bits({p, a, 1'b0, 1'b1, rsv}, 8, 1'b0);
    if (split) begin sel_high(); sel_low(); end
    shift_bits(d, 8, 1'b0);
    sel_high();
    model[a] = d; model_pwr = p;
    settle_and_check(req);
  endtask

  task automatic do_read(input logic [3:0] a, input logic p, input bit split,
                         input string req);
    exp_q.push_back(model[a]);
    sel_low();
    shift_bits({p, a, 1'b1, 1'b1, 1'b0}, 8, 1'b0);
    if (split) begin sel_high(); sel_low(); end
    shift_bits(8'h00, 8, 1'b1);
    sel_high();
    model_pwr = p;
    settle_and_check(req);
  endtask

  task automatic do_power(input logic p, input logic [5:0] junk, input string req);
    sel_low();
    shift_bits({p, junk[3:0], junk[4], 1'b0, junk[5]}, 8, 1'b0);
    sel_high();
    model_pwr = p;
    settle_and_check(req);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      check(1'b0, "watchdog expired", 128'd0, 128'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    model_pwr = 1'b1;
    #50 rst_n = 1'b1; #40;

    // R10 reset state, R5 idle output enable
    check(cfg_regs === 128'd0, "R10 regs after reset", cfg_regs, 128'd0);
    check(pwr_down === 1'b1, "R10 power after reset", {127'd0, pwr_down}, 128'd1);
    check(cdo_oe === 1'b0, "R5 oe after reset", {127'd0, cdo_oe}, 128'd0);

    // R3 R7 R9: contiguous write while powered down, power up with it
    do_write(4'd3, 8'hA5, 1'b0, 1'b0, 1'b0, "R3 R9 contiguous write");
    // R2 R3: split write, reserved bit set
    do_write(4'd15, 8'h3C, 1'b0, 1'b1, 1'b1, "R2 R3 split write");
    // R1: bit order
    do_write(4'd0, 8'h81, 1'b0, 1'b0, 1'b0, "R1 msb first");
    // R4 reads, contiguous and split; R7 power bit on read
    do_read(4'd3, 1'b0, 1'b0, "R4 contiguous read");
    do_read(4'd15, 1'b1, 1'b1, "R4 R7 split read");
    // R9: write while powered down, keep down
    do_write(4'd7, 8'h5A, 1'b1, 1'b0, 1'b0, "R9 write while down");
    // R6: single-byte power up with junk address and read bits
    do_power(1'b0, 6'b111111, "R6 single-byte power up");
    do_power(1'b1, 6'b010110, "R6 single-byte power down");
    // R7: two-byte write applies its power bit
    do_write(4'd9, 8'h11, 1'b0, 1'b1, 1'b0, "R7 power from write");

    // R8: partial header discarded
    sel_low();
    shift_bits({1'b1, 4'd7, 1'b0, 1'b1, 1'b0}, 5, 1'b0);
    sel_high();
    settle_and_check("R8 partial header");
    do_write(4'd12, 8'hC3, 1'b0, 1'b0, 1'b0, "R8 write after abort");

    // R8: pending data byte aborted, next byte must be a header
    sel_low();
    shift_bits({1'b0, 4'd9, 1'b0, 1'b1, 1'b0}, 8, 1'b0);
    sel_high();
    sel_low();
    shift_bits(8'hFF, 3, 1'b0);
    sel_high();
    settle_and_check("R8 aborted data byte");
    do_power(1'b1, 6'b000000, "R8 idle after abort");

    // R4 R1: read back register 0 and register 12
    do_read(4'd0, 1'b1, 1'b0, "R4 read reg0");
    do_read(4'd12, 1'b0, 1'b1, "R4 read reg12");

    #100;
    check(exp_q.size() == 0, "R4 reads outstanding", exp_q.size(), 128'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule